// File: doc/BRIEF.md
# MDIO management frame master

This block is a station-management master. It runs one read or one write of a single PHY register per command, over a two-wire management bus: a clock (MDC) that the block generates, and a bidirectional data line (MDIO). The block drives MDIO through an output value and an output enable, so the line can be released to the PHY. A host starts a transaction with a one-cycle `start` strobe. With the strobe it gives a read/write select, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. It then waits for `busy` to fall. After a read, `rdata` holds the register value.

MDC is the system clock divided by `MDC_DIV`. It is low for `MDC_DIV/2` (rounded down) system clocks of each bit slot and high for the rest, and it rests low between transactions. Every frame lasts exactly 65 bit slots: 32 preamble ones, start-of-frame `01`, the opcode (`01` for write, `10` for read), the PHY address and then the register address (each MSB first), a 2-bit turnaround, 16 data bits (MSB first), and one final slot in which the line is released.

A single finite-state machine sequences the frame. Its states are IDLE, PRE (preamble), SOF (start-of-frame), OPC (opcode), PHY (PHY address), REG (register address), TURN (turnaround), DATA (data bits) and REL (release slot). The transitions are:
- IDLE→PRE when a start strobe is accepted.
- PRE→SOF, SOF→OPC, OPC→PHY, PHY→REG, REG→TURN, TURN→DATA, DATA→REL and REL→IDLE. Each of these happens at the end of the last bit slot of the current field.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever `busy` is low, `mdc` is low and `mdio_oe` is low.
- R2: During a frame, MDC gives exactly 65 pulses. Each high phase lasts `MDC_DIV - MDC_DIV/2` system clocks, and MDC is never high while `busy` is low.
- R3: Each frame, as seen on MDC rising edges, starts with 32 ones, then `01`, then the opcode (`01` write, `10` read), then the 5-bit PHY address and the 5-bit register address, both MSB first.
- R4: In a write, the master drives the turnaround as `10` in bit slots 46–47. It then drives the 16 write-data bits, MSB first, in slots 48–63.
- R5: In a read, the master releases MDIO from slot 46 through the end of the frame. It samples MDIO one system clock after each MDC falling edge of slots 48–63, and the first bit received becomes bit 15 of `rdata`. With no PHY driving, the pulled-up line reads as 16'hFFFF.
- R6: While MDIO is driven, its value changes only at the start of a bit slot, with MDC low. It never changes while MDC is high.
- R7: For both frame types, the 65th slot (slot 64) has MDC pulse once with `mdio_oe` low. The enable is also low in the last cycle before `busy` falls.
- R8: `busy` rises in the cycle after a start strobe is accepted while idle. It then stays high for exactly 65×`MDC_DIV` system clocks.
- R9: A start strobe that arrives while `busy` is high is ignored. The running frame keeps its command, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle command strobe |
| is_read | input | 1 | 1 = read, 0 = write; sampled with `start` |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid once `busy` has fallen after a read |
| busy | output | 1 | High from command acceptance until the release slot ends |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, 1 = master drives the line |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The bench attaches a small PHY model with 32 registers. It writes values with extreme bit patterns (all ones, only the MSB set, only the LSB set) to the first and last register addresses and reads them back. A design that shifted the wrong way or sampled on the wrong edge would return a bit-reversed or shifted value. Reads to an absent PHY address must return all ones, and a write to another PHY must leave the addressed PHY untouched. A master that did not release the line on time would collide with the PHY during the read turnaround or the release slot, and the bench counts any such contention. A strobe injected mid-frame with a different command must change neither the header on the wire nor the frame length, and must not start a second frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_BITS = 5;
    localparam int DATA_BITS = 16;
    localparam int PRE_BITS  = 32;
    localparam int SOF_BITS  = 2;
    localparam int OPC_BITS  = 2;
    localparam int TURN_BITS = 2;
    localparam int HDR_BITS  = SOF_BITS + OPC_BITS + 2 * ADDR_BITS + TURN_BITS + DATA_BITS;
    localparam int CNT_W     = $clog2(PRE_BITS + 1);

    localparam logic [SOF_BITS-1:0]  SOF_CODE  = 2'b01;
    localparam logic [OPC_BITS-1:0]  OPC_WRITE = 2'b01;
    localparam logic [OPC_BITS-1:0]  OPC_READ  = 2'b10;
    localparam logic [TURN_BITS-1:0] TURN_WR   = 2'b10;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_SOF,
        ST_OPC,
        ST_PHY,
        ST_REG,
        ST_TURN,
        ST_DATA,
        ST_REL
    } mdio_state_t;

    // number of bit slots spent in each frame field
    function automatic logic [CNT_W-1:0] field_slots(input mdio_state_t s);
        unique case (s)
            ST_PRE:  field_slots = CNT_W'(PRE_BITS);
            ST_SOF:  field_slots = CNT_W'(SOF_BITS);
            ST_OPC:  field_slots = CNT_W'(OPC_BITS);
            ST_PHY:  field_slots = CNT_W'(ADDR_BITS);
            ST_REG:  field_slots = CNT_W'(ADDR_BITS);
            ST_TURN: field_slots = CNT_W'(TURN_BITS);
            ST_DATA: field_slots = CNT_W'(DATA_BITS);
            default: field_slots = CNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV = 102
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic slot_end,
    output logic slot_begin
);
    localparam int CW      = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int LOW_LEN = DIV / 2;

    logic [CW-1:0] cnt;

    assign slot_end = run && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            mdc        <= 1'b0;
            slot_begin <= 1'b0;
        end else begin
            slot_begin <= slot_end;
            if (!run) begin
                cnt <= '0;
                mdc <= 1'b0;
            end else if (cnt == CW'(DIV - 1)) begin
                cnt <= '0;
                mdc <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
                if (cnt == CW'(LOW_LEN - 1))
                    mdc <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
    parameter int TX_W = 32,
    parameter int RX_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_word,
    input  logic            shift_en,
    input  logic            sample_en,
    input  logic            line_in,
    output logic            tx_bit,
    output logic [RX_W-1:0] rx_word
);
    logic [TX_W-1:0] tx_q;

    assign tx_bit = tx_q[TX_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_word <= '0;
        end else begin
            if (load)
                tx_q <= load_word;
            else if (shift_en)
                tx_q <= {tx_q[TX_W-2:0], 1'b0};
            if (sample_en)
                rx_word <= {rx_word[RX_W-2:0], line_in};
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_DIV = 102
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 is_read,
    input  logic [ADDR_BITS-1:0] phy_addr,
    input  logic [ADDR_BITS-1:0] reg_addr,
    input  logic [DATA_BITS-1:0] wdata,
    output logic [DATA_BITS-1:0] rdata,
    output logic                 busy,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i
);
    mdio_state_t       state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rd_q, rd_pend;
    logic              run, slot_end, slot_begin;
    logic              last_bit, adv, accept;
    logic              shift_en, sample_en, tx_bit;
    logic [HDR_BITS-1:0] hdr_word;

    assign accept   = (state == ST_IDLE) && start;
    assign last_bit = (bit_cnt == field_slots(state) - 1'b1);
    assign adv      = slot_end && last_bit;
    assign shift_en = slot_end && (state inside {ST_SOF, ST_OPC, ST_PHY, ST_REG, ST_TURN, ST_DATA});
    assign sample_en = slot_begin && rd_pend;
    assign hdr_word = {SOF_CODE, (is_read ? OPC_READ : OPC_WRITE), phy_addr, reg_addr, TURN_WR, wdata};

    mdio_clkdiv #(.DIV(MDC_DIV)) u_clkdiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .mdc        (mdc),
        .slot_end   (slot_end),
        .slot_begin (slot_begin)
    );

    mdio_shifter #(.TX_W(HDR_BITS), .RX_W(DATA_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (hdr_word),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .line_in   (mdio_i),
        .tx_bit    (tx_bit),
        .rx_word   (rdata)
    );

    // state register and per-field slot counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rd_q    <= 1'b0;
            rd_pend <= 1'b0;
        end else begin
            state <= nxt;
            if (accept || adv)
                bit_cnt <= '0;
            else if (slot_end)
                bit_cnt <= bit_cnt + 1'b1;
            if (accept)
                rd_q <= is_read;
            if (slot_end)
                rd_pend <= (state == ST_DATA) && rd_q;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_PRE;
            ST_PRE:  if (adv)   nxt = ST_SOF;
            ST_SOF:  if (adv)   nxt = ST_OPC;
            ST_OPC:  if (adv)   nxt = ST_PHY;
            ST_PHY:  if (adv)   nxt = ST_REG;
            ST_REG:  if (adv)   nxt = ST_TURN;
            ST_TURN: if (adv)   nxt = ST_DATA;
            ST_DATA: if (adv)   nxt = ST_REL;
            ST_REL:  if (adv)   nxt = ST_IDLE;
            default:            nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        run     = busy;
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state)
            ST_PRE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_SOF, ST_OPC, ST_PHY, ST_REG: begin
                mdio_o  = tx_bit;
                mdio_oe = 1'b1;
            end
            ST_TURN, ST_DATA: begin
                mdio_o  = tx_bit;
                mdio_oe = !rd_q;
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    a_r2_mdc_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> busy);

    a_r6_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc) && mdio_oe && $past(mdio_oe)) |-> $stable(mdio_o));

    a_r7_released_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(mdio_oe));

    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int DIV    = 8;
    localparam int HI_LEN = DIV - DIV / 2;
    localparam int SLOTS  = 65;
    localparam logic [4:0] MY_PHY = 5'd3;

    typedef struct {
        bit          rd;
        logic [4:0]  pa;
        logic [4:0]  ra;
        logic [15:0] wd;
        logic [15:0] exp;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, is_read = 1'b0;
    logic [4:0]  phy_addr = '0, reg_addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic busy, mdc, mdio_o, mdio_oe;
    logic phy_oe = 1'b0, phy_o = 1'b0;
    logic line;

    assign line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    always #2 clk = ~clk;

    mdio_master #(.MDC_DIV(DIV)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(line)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    item_t sb_q[$];
    logic [15:0] mirror [32];

    function automatic logic [15:0] init_val(input int i);
        return 16'h5A00 ^ 16'(i * 16'h0107);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // ---------------- PHY model ----------------
    logic [15:0] regs [32];
    int          ridx = 0;
    logic [13:0] hdr_w;
    logic [17:0] tawd_w;
    bit          pre_bad_w, oe_bad_w;
    logic [13:0] f_hdr;
    logic [17:0] f_tawd;
    bit          f_pre_bad, f_oe_bad;

    initial for (int i = 0; i < 32; i++) begin
        regs[i]   = init_val(i);
        mirror[i] = init_val(i);
    end

    always @(posedge mdc) begin
        logic b;
        logic wr;
        logic hit_rd;
        b = line;
        if (ridx == 0) begin
            pre_bad_w = 0;
            oe_bad_w  = 0;
        end
        if (ridx < 32) begin
            if (!b) pre_bad_w = 1;
        end else if (ridx < 46) begin
            hdr_w = {hdr_w[12:0], b};
        end else if (ridx < 64) begin
            tawd_w = {tawd_w[16:0], b};
        end
        wr = (hdr_w[11:10] == 2'b01);
        hit_rd = (hdr_w[11:10] == 2'b10) && (hdr_w[9:5] == MY_PHY);
        if (ridx < 46 && !mdio_oe) oe_bad_w = 1;
        if (ridx >= 46 && ridx < 64 && (mdio_oe != wr)) oe_bad_w = 1;
        if (ridx == 64 && mdio_oe) oe_bad_w = 1;
        if (ridx == 47 && hit_rd) begin
            phy_oe = 1'b1;
            phy_o  = 1'b0;
        end else if (ridx >= 48 && ridx < 64 && hit_rd) begin
            phy_o = regs[hdr_w[4:0]][63 - ridx];
        end
        if (ridx == 64) begin
            phy_oe = 1'b0;
            if (wr && hdr_w[9:5] == MY_PHY) regs[hdr_w[4:0]] = tawd_w[15:0];
            f_hdr = hdr_w; f_tawd = tawd_w;
            f_pre_bad = pre_bad_w; f_oe_bad = oe_bad_w;
            ridx = 0;
        end else begin
            ridx++;
        end
    end

    // ---------------- monitor / scoreboard ----------------
    int  busy_len = 0, rises = 0, hi_run = 0, hi_bad = 0, setup_bad = 0, cont_bad = 0;
    logic p_busy = 0, p_mdc = 0, p_oe = 0, p_o = 0;

    initial forever begin
        @(negedge clk);
        if (busy) busy_len++;
        if (mdc && !p_mdc) rises++;
        if (mdc) hi_run++;
        else begin
            if (p_mdc && hi_run != HI_LEN) hi_bad++;
            hi_run = 0;
        end
        if (mdc && p_mdc && mdio_oe && p_oe && mdio_o != p_o) setup_bad++;
        if (mdio_oe && phy_oe) cont_bad++;
        if (p_busy && !busy) begin
            item_t it;
            logic [13:0] eh;
            if (sb_q.size() == 0) begin
                chk(0, "R8 unexpected frame", 0, 0);
            end else begin
                it = sb_q.pop_front();
                eh = {2'b01, (it.rd ? 2'b10 : 2'b01), it.pa, it.ra};
                chk(busy_len == SLOTS * DIV, "R8 busy length", busy_len, SLOTS * DIV);
                chk(rises == SLOTS, "R2 mdc pulses per frame", rises, SLOTS);
                chk(hi_bad == 0, "R2 mdc high width", hi_bad, 0);
                chk(!f_pre_bad, "R3 preamble ones", f_pre_bad, 0);
                chk(f_hdr == eh, "R3 header fields", f_hdr, eh);
                chk(!f_oe_bad, "R5/R7 drive and release slots", f_oe_bad, 0);
                chk(cont_bad == 0, "R5 R7 no contention", cont_bad, 0);
                chk(setup_bad == 0, "R6 change only while mdc low", setup_bad, 0);
                if (it.rd)
                    chk(rdata == it.exp, "R5 read data", rdata, it.exp);
                else
                    chk(f_tawd == {2'b10, it.wd}, "R4 turnaround and data", f_tawd, {2'b10, it.wd});
            end
            busy_len = 0; rises = 0; hi_bad = 0; setup_bad = 0; cont_bad = 0;
        end
        p_busy = busy; p_mdc = mdc; p_oe = mdio_oe; p_o = mdio_o;
    end

    // ---------------- driver ----------------
    task automatic do_cmd(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input bit poke);
        item_t it;
        it.rd = rd; it.pa = pa; it.ra = ra; it.wd = wd;
        it.exp = rd ? ((pa == MY_PHY) ? mirror[ra] : 16'hFFFF) : 16'h0000;
        if (!rd && pa == MY_PHY) mirror[ra] = wd;
        sb_q.push_back(it);
        @(negedge clk);
        start = 1'b1; is_read = rd; phy_addr = pa; reg_addr = ra; wdata = wd;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy one cycle after start", busy, 1);
        if (poke) begin
            repeat (100) @(negedge clk);
            start = 1'b1; is_read = ~rd; phy_addr = pa ^ 5'd1; reg_addr = ra ^ 5'd7; wdata = ~wd;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        if (poke) begin
            bit stayed;
            stayed = 1;
            repeat (20) begin
                @(negedge clk);
                if (busy) stayed = 0;
            end
            chk(stayed, "R9 no frame from strobe while busy", !stayed, 0);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0, "R1 busy after reset", busy, 0);
        chk(mdc == 0, "R1 mdc after reset", mdc, 0);
        chk(mdio_oe == 0, "R1 oe after reset", mdio_oe, 0);
        repeat (10) @(negedge clk);
        chk(mdc == 0 && !mdio_oe, "R1 idle quiet", {mdc, mdio_oe}, 0);

        do_cmd(0, MY_PHY, 5'd5, 16'hC3A5, 0);
        do_cmd(1, MY_PHY, 5'd5, 16'h0000, 0);
        do_cmd(0, MY_PHY, 5'd0, 16'h0001, 0);
        do_cmd(1, MY_PHY, 5'd0, 16'h0000, 0);
        do_cmd(0, MY_PHY, 5'd31, 16'h8000, 0);
        do_cmd(1, MY_PHY, 5'd31, 16'h0000, 0);
        do_cmd(1, MY_PHY, 5'd7, 16'h0000, 0);
        do_cmd(1, 5'd9, 5'd5, 16'h0000, 0);
        do_cmd(0, 5'd9, 5'd5, 16'h1234, 0);
        do_cmd(1, MY_PHY, 5'd5, 16'h0000, 0);
        do_cmd(0, MY_PHY, 5'd12, 16'hFFFF, 1);
        do_cmd(1, MY_PHY, 5'd12, 16'h0000, 0);
        do_cmd(1, MY_PHY, 5'd4, 16'h0000, 1);

        repeat (5) @(negedge clk);
        chk(sb_q.size() == 0, "R8 all frames completed", sb_q.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog act=%0d exp=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule